// File: doc/BRIEF.md
# Compare-and-Skip Sequencing Unit

This unit executes the "compare two registers, skip the next instruction if they match" operation of a small 8-bit core with 32 general registers and 16-bit instruction words. When an instruction word is presented with its valid strobe, the unit recognises the opcode and extracts the two 5-bit register indices. It drives them onto two register-file read ports and compares the two returned bytes in the same cycle. It also partly decodes the word that follows in program memory, to learn whether that instruction spans one word or two.

From the compare result and the length of the following instruction, the unit starts a short execution window. The window lasts one, two or three cycles and carries the program-counter increment that the fetch stage must apply. Each cycle that stands for a skipped word raises a squash strobe, so the pipeline can suppress register and memory writes for that word. The unit writes no status flags. The register file, instruction memory and the rest of the pipeline sit outside it and are reached only through its ports.

Top module: `cmp_skip_unit`

## Requirements
- R1: A word is recognised as the compare-skip opcode only when bits 15:10 equal 6'b000100 and the valid strobe is high while the unit is idle. Any other word starts no execution window, and the active output stays low.
- R2: The first read address is {word[8], word[7:4]} and the second is {word[9], word[3:0]}. Both are driven combinationally, and any index from 0 to 31 is reachable on either port.
- R3: When the two register bytes differ, the execution window lasts exactly one cycle. During it the increment is 1, skip-valid is low and squash is never raised.
- R4: When the bytes are equal and the following word is a one-word instruction, the window lasts two cycles with increment 2 and skip-valid high. Squash is high in the second cycle only.
- R5: When the bytes are equal and the following word is a two-word instruction, the window lasts three cycles with increment 3 and skip-valid high. Squash is high in the second and third cycles.
- R6: The following word counts as two words when (w & 16'hFE0E) is 16'h940C or 16'h940E (absolute jump, absolute call), or when (w & 16'hFE0F) is 16'h9000 or 16'h9200 (direct load, direct store). Every other word counts as one word.
- R7: The increment and skip-valid hold their values for the whole window. Stall is high in every window cycle except the last, done is high only in the last, and active drops in the cycle after done.
- R8: A valid strobe that arrives while a window is open is ignored. It changes neither the running window's outputs nor its length, and no new window follows unless the strobe is presented again while idle.
- R9: After reset, active, skip-valid, squash, stall and done are low and the increment is 0. Outside an execution window they stay at those values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid_i | input | 1 | Instruction word is presented for issue |
| instr_word_i | input | 16 | Instruction word under issue |
| follow_word_i | input | 16 | Program word at PC+1 |
| rf_addr_a_o | output | 5 | Register-file read address, first operand |
| rf_addr_b_o | output | 5 | Register-file read address, second operand |
| rf_data_a_i | input | 8 | Register-file read data, first operand |
| rf_data_b_i | input | 8 | Register-file read data, second operand |
| active_o | output | 1 | An execution window is open |
| skip_valid_o | output | 1 | The open window performs a skip |
| pc_inc_o | output | 2 | Program-counter increment for the open window |
| squash_o | output | 1 | The current cycle stands for a skipped word |
| stall_o | output | 1 | Hold issue; more window cycles follow |
| done_o | output | 1 | Last cycle of the window |

## Verification
A corrupted phase counter or length latch shows at the ports as a window that is one cycle too short or too long. It also shows as squash or stall raised in the wrong phase, and both appear within three cycles of issue. A corrupted skip or increment latch appears as a pc_inc value that disagrees with the compare outcome, or one that changes in mid-window, and it shows in the first window cycle. A decode fault in the length mask shows as an increment of 2 where 3 belongs, or the reverse, when the bench walks each two-word class and a near-miss pattern.

// File: rtl/cps_pkg.sv
package cps_pkg;
    localparam int WORD_W    = 16;
    localparam int IDX_W     = 5;
    localparam int NUM_LONG  = 4;
    localparam int PH_W      = 2;

    // opcode class of the compare-skip instruction (bits 15:10)
    localparam logic [5:0] CPS_CLASS = 6'b000100;

    // two-word instruction patterns: jump, call, direct load, direct store
    localparam logic [NUM_LONG*WORD_W-1:0] LONG_MASKS =
        {16'hFE0F, 16'hFE0F, 16'hFE0E, 16'hFE0E};
    localparam logic [NUM_LONG*WORD_W-1:0] LONG_VALUES =
        {16'h9200, 16'h9000, 16'h940E, 16'h940C};

    typedef struct packed {
        logic            active;
        logic            skip;
        logic [PH_W-1:0] inc;
        logic [PH_W-1:0] last;
        logic [PH_W-1:0] ph;
    } seq_state_t;
endpackage

// File: rtl/cps_decode.sv
module cps_decode
    import cps_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              is_cps_o,
    output logic [IDX_W-1:0]  idx_a_o,
    output logic [IDX_W-1:0]  idx_b_o
);
    always_comb begin
        is_cps_o = (word_i[15:10] == CPS_CLASS);
        idx_a_o  = {word_i[8], word_i[7:4]};
        idx_b_o  = {word_i[9], word_i[3:0]};
    end
endmodule

// File: rtl/cps_len_detect.sv
module cps_len_detect
    import cps_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output logic              two_word_o
);
    logic [NUM_LONG-1:0] hit;

    for (genvar i = 0; i < NUM_LONG; i++) begin : g_pat
        assign hit[i] = (word_i & LONG_MASKS[i*WORD_W +: WORD_W])
                        == LONG_VALUES[i*WORD_W +: WORD_W];
    end

    assign two_word_o = |hit;

    // R6: the patterns are disjoint, at most one class matches
    always_comb begin
        hit_disjoint_chk: assert ($onehot0(hit));
    end
endmodule

// File: rtl/cps_seq.sv
module cps_seq
    import cps_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            equal_i,
    input  logic            two_word_i,
    output logic            active_o,
    output logic            skip_valid_o,
    output logic [PH_W-1:0] pc_inc_o,
    output logic            squash_o,
    output logic            stall_o,
    output logic            done_o
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.ph == st_q.last) begin
                st_d = '0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end else if (start_i) begin
            st_d.active = 1'b1;
            st_d.skip   = equal_i;
            st_d.inc    = !equal_i ? 2'd1 : (two_word_i ? 2'd3 : 2'd2);
            st_d.last   = st_d.inc - 2'd1;
            st_d.ph     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o     = st_q.active;
    assign skip_valid_o = st_q.active & st_q.skip;
    assign pc_inc_o     = st_q.active ? st_q.inc : '0;
    assign squash_o     = st_q.active && (st_q.ph != '0);
    assign stall_o      = st_q.active && (st_q.ph != st_q.last);
    assign done_o       = st_q.active && (st_q.ph == st_q.last);

    // R7
    // pc_inc_hold_chk: increment and skip fixed until the window closes
    pc_inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !done_o) |=> ($stable(pc_inc_o) && $stable(skip_valid_o)));

    // R7
    window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !active_o);

    // R3
    no_skip_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !skip_valid_o) |-> (pc_inc_o == 2'd1 && done_o && !squash_o));

    // R4
    squash_needs_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> skip_valid_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (pc_inc_o == '0 && !squash_o && !stall_o && !done_o && !skip_valid_o));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !done_o) |=> active_o);
endmodule

// File: rtl/cmp_skip_unit.sv
module cmp_skip_unit
    import cps_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid_i,
    input  logic [15:0]       instr_word_i,
    input  logic [15:0]       follow_word_i,
    output logic [4:0]        rf_addr_a_o,
    output logic [4:0]        rf_addr_b_o,
    input  logic [DATA_W-1:0] rf_data_a_i,
    input  logic [DATA_W-1:0] rf_data_b_i,
    output logic              active_o,
    output logic              skip_valid_o,
    output logic [1:0]        pc_inc_o,
    output logic              squash_o,
    output logic              stall_o,
    output logic              done_o
);
    logic is_cps;
    logic two_word;
    logic equal;
    logic start;

    cps_decode u_dec (
        .word_i   (instr_word_i),
        .is_cps_o (is_cps),
        .idx_a_o  (rf_addr_a_o),
        .idx_b_o  (rf_addr_b_o)
    );

    cps_len_detect u_len (
        .word_i     (follow_word_i),
        .two_word_o (two_word)
    );

    assign equal = (rf_data_a_i == rf_data_b_i);
    assign start = instr_valid_i & is_cps;

    cps_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .equal_i      (equal),
        .two_word_i   (two_word),
        .active_o     (active_o),
        .skip_valid_o (skip_valid_o),
        .pc_inc_o     (pc_inc_o),
        .squash_o     (squash_o),
        .stall_o      (stall_o),
        .done_o       (done_o)
    );

    // R1
    // start_decode_chk: a window opens only from an idle unit on a recognised word
    start_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start) |=> !active_o);
endmodule

// File: tb/tb_cmp_skip_unit.sv
module tb_cmp_skip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [15:0] instr_word_i = '0;
    logic [15:0] follow_word_i = '0;
    logic [4:0]  rf_addr_a_o, rf_addr_b_o;
    logic [7:0]  rf_data_a_i, rf_data_b_i;
    logic        active_o, skip_valid_o, squash_o, stall_o, done_o;
    logic [1:0]  pc_inc_o;

    logic [7:0] regs [32];
    int tests = 0;
    int fails = 0;
    int exp_q [$];

    always #10 clk = ~clk;

    assign rf_data_a_i = regs[rf_addr_a_o];
    assign rf_data_b_i = regs[rf_addr_b_o];

    cmp_skip_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i),
        .instr_word_i(instr_word_i), .follow_word_i(follow_word_i),
        .rf_addr_a_o(rf_addr_a_o), .rf_addr_b_o(rf_addr_b_o),
        .rf_data_a_i(rf_data_a_i), .rf_data_b_i(rf_data_b_i),
        .active_o(active_o), .skip_valid_o(skip_valid_o), .pc_inc_o(pc_inc_o),
        .squash_o(squash_o), .stall_o(stall_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    function automatic logic [15:0] enc(input int d, input int r);
        logic [4:0] dd = 5'(d);
        logic [4:0] rr = 5'(r);
        return {6'b000100, rr[4], dd[4], dd[3:0], rr[3:0]};
    endfunction

    function automatic bit is_long(input logic [15:0] w);
        return ((w & 16'hFE0E) == 16'h940C) || ((w & 16'hFE0E) == 16'h940E) ||
               ((w & 16'hFE0F) == 16'h9000) || ((w & 16'hFE0F) == 16'h9200);
    endfunction

    // monitor: compares each window cycle against the popped expectation
    int  mon_cyc = 0;
    int  mon_ph  = 0;
    bit  mon_busy = 0;
    always @(negedge clk) begin
        if (rst_n && active_o) begin
            if (!mon_busy) begin
                if (exp_q.size() == 0) begin
                    check(0, "R1", "unexpected window", 1, 0);
                    mon_cyc = 1;
                end else begin
                    mon_cyc = exp_q.pop_front();
                end
                mon_busy = 1;
                mon_ph   = 0;
            end
            check(pc_inc_o == 2'(mon_cyc), mon_cyc == 1 ? "R3" : (mon_cyc == 2 ? "R4" : "R5"),
                  "pc_inc", pc_inc_o, mon_cyc);
            check(skip_valid_o == (mon_cyc > 1), "R7", "skip_valid", skip_valid_o, mon_cyc > 1);
            check(squash_o == (mon_ph > 0), mon_cyc == 3 ? "R5" : "R4", "squash",
                  squash_o, mon_ph > 0);
            check(stall_o == (mon_ph < mon_cyc - 1), "R7", "stall", stall_o, mon_ph < mon_cyc - 1);
            check(done_o == (mon_ph == mon_cyc - 1), "R7", "done", done_o, mon_ph == mon_cyc - 1);
            mon_ph++;
            if (done_o || mon_ph >= mon_cyc) mon_busy = 0;
        end else if (rst_n && mon_busy) begin
            check(0, "R7", "window ended early at phase", mon_ph, mon_cyc);
            mon_busy = 0;
        end
    end

    task automatic check_idle(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(!active_o && pc_inc_o == 0 && !squash_o && !stall_o && !done_o && !skip_valid_o,
                  req, "idle outputs", {active_o, pc_inc_o, squash_o, stall_o, done_o}, 0);
        end
    endtask

    // driver: sets up registers, pushes expectation, issues the word
    task automatic run_cps(input int d, input int r, input logic [7:0] vd,
                           input logic [7:0] vr, input logic [15:0] nw,
                           input bit busy_poke);
        int cyc;
        regs[d] = vd;
        regs[r] = vr;
        cyc = (regs[d] != regs[r]) ? 1 : (is_long(nw) ? 3 : 2);
        exp_q.push_back(cyc);
        @(negedge clk);
        instr_word_i  = enc(d, r);
        follow_word_i = nw;
        instr_valid_i = 1'b1;
        #1;
        check(rf_addr_a_o == 5'(d), "R2", "addr_a", rf_addr_a_o, d);
        check(rf_addr_b_o == 5'(r), "R2", "addr_b", rf_addr_b_o, r);
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (busy_poke && k < cyc - 1) begin
                // R8: a different recognised word with unequal data while busy
                instr_word_i  = enc(5, 6);
                follow_word_i = 16'h940C;
                regs[5] = 8'h11;
                regs[6] = 8'h22;
                instr_valid_i = 1'b1;
            end else begin
                instr_valid_i = 1'b0;
            end
        end
        check_idle(busy_poke ? "R8" : "R9", 1);
    endtask

    initial begin
        #(20 * 5000);
        check(0, "R9", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        check_idle("R9", 1);
        rst_n = 1'b1;
        check_idle("R9", 2);

        // R3: unequal, index extremes
        run_cps(0, 31, 8'h00, 8'hFF, 16'h0000, 0);
        run_cps(31, 0, 8'h10, 8'h11, 16'h940C, 0);
        // R4: equal, one-word next (including near miss of the long patterns)
        run_cps(17, 16, 8'h5A, 8'h5A, 16'h0C00, 0);
        run_cps(3, 20, 8'hAA, 8'hAA, 16'h9401, 0);
        run_cps(4, 4, 8'h33, 8'h33, 16'h9201, 0);
        // R5/R6: each two-word class
        run_cps(1, 2, 8'h77, 8'h77, 16'h940C, 0);
        run_cps(8, 9, 8'h01, 8'h01, 16'h95FF, 0);
        run_cps(30, 15, 8'hC3, 8'hC3, 16'h91F0, 0);
        run_cps(12, 28, 8'h00, 8'h00, 16'h9350, 0);
        // R8: strobes during a three-cycle and a two-cycle window
        run_cps(10, 11, 8'h42, 8'h42, 16'h940E, 1);
        run_cps(13, 14, 8'h42, 8'h42, 16'h1234, 1);

        // R1: non-matching opcode words start nothing
        @(negedge clk);
        instr_word_i  = 16'h0C00;
        follow_word_i = 16'h940C;
        instr_valid_i = 1'b1;
        @(negedge clk);
        instr_word_i  = 16'h1400;
        @(negedge clk);
        instr_valid_i = 1'b0;
        check_idle("R1", 2);
        // R1: recognised word without valid strobe
        instr_word_i = enc(2, 2);
        check_idle("R1", 2);

        check(exp_q.size() == 0, "R7", "pending expectations", exp_q.size(), 0);
        summary();
    end
endmodule